// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Loader

This block sits between a byte-wide host register port and four 12-bit converter channels. Each channel has two registers: an input latch and an output register. A host loads a channel in two steps. First it writes the low eight data bits. Then it writes a high byte that holds the top four data bits and a two-bit channel number. The high-byte write starts a transfer of fixed length. While the transfer runs, the block reports busy. When the transfer ends, the word is placed in the selected channel's input latch.

The input latches do not reach the outputs on their own. All four outputs take their latched values together when the host reads the high-byte address while no transfer is running. This lets a host prepare several channels and then change them all in the same cycle. The transfer length is a cycle count that the host supplies. The latched values and the output values are both brought out as flat buses.

Top module: `dac_dbuf_loader`

## Requirements
- R1: After reset, every input latch and every output is zero, and busy is clear.
- R2: A write to offset 4 stores the low data byte. A write to offset 5 while idle forms the word {wdata[3:0], low byte} and selects channel wdata[7:6]. Bits 5:4 of that byte are ignored.
- R3: A read of offset 4 returns busy in bit 7, with bits 6:0 zero. Reads of any other offset return zero. Busy is set for N cycles after the edge that takes the high-byte write. N is xfer_cycles_i at that edge, and a value of 0 counts as 1.
- R4: At the edge where busy clears, the selected channel's latch (channel k at bits 12k+11:12k) takes the word. The other latches do not change, and no output changes.
- R5: A high-byte write while busy is ignored. It does not change the transfer in flight, its length or any latch.
- R6: The low byte keeps its value across transfers until offset 4 is written again.
- R7: A read of offset 5 while idle copies all four latches to all four outputs at the same edge.
- R8: A read of offset 5 while busy leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| addr_i | input | ADDR_W | Host register offset |
| wdata_i | input | 8 | Host write byte |
| xfer_cycles_i | input | CNT_W | Transfer length in cycles |
| rdata_o | output | 8 | Host read byte |
| latch_o | output | 48 | Input latches, channel k at bits 12k+11:12k |
| dac_o | output | 48 | Channel outputs, channel k at bits 12k+11:12k |

## Verification
The assertions assume that the host issues at most one access per cycle, that every input holds a known value, and that xfer_cycles_i matters only at the edge that takes a high-byte write. In every cycle the stimulus raises either one strobe or none. It draws offsets mostly from 4 and 5, with the rest spread over other offsets. It changes the transfer length freely between writes. This places high-byte writes and update reads inside transfers, on the cycle a transfer ends, and right after one ends.

// File: rtl/dac_ld_pkg.sv
package dac_ld_pkg;
  localparam int BYTE_W   = 8;
  localparam int DATA_W   = 12;
  localparam int NUM_CH   = 4;
  localparam int CH_W     = $clog2(NUM_CH);
  localparam int HI_DW    = DATA_W - BYTE_W;
  localparam int CH_LSB   = BYTE_W - CH_W;
  localparam int OFS_LO   = 4;
  localparam int OFS_HI   = 5;
  localparam int BUSY_BIT = 7;

  typedef struct packed {
    logic [CH_W-1:0]   ch;
    logic [DATA_W-1:0] word;
  } xfer_req_t;
endpackage

// File: rtl/dac_ld_regif.sv
module dac_ld_regif
  import dac_ld_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              busy_i,
  output logic              start_o,
  output xfer_req_t         req_o,
  output logic              upd_o,
  output logic [BYTE_W-1:0] rdata_o
);
  logic [BYTE_W-1:0] lo_q;
  logic sel_lo, sel_hi;

  assign sel_lo = (addr_i == ADDR_W'(OFS_LO));
  assign sel_hi = (addr_i == ADDR_W'(OFS_HI));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                lo_q <= '0;
    else if (wr_en_i && sel_lo) lo_q <= wdata_i;
  end

  assign start_o    = wr_en_i && sel_hi && !busy_i;
  assign req_o.ch   = wdata_i[BYTE_W-1:CH_LSB];
  assign req_o.word = {wdata_i[HI_DW-1:0], lo_q};
  assign upd_o      = rd_en_i && sel_hi && !busy_i;

  always_comb begin
    rdata_o = '0;
    if (rd_en_i && sel_lo) rdata_o[BUSY_BIT] = busy_i;
  end
endmodule

// File: rtl/dac_ld_xfer.sv
module dac_ld_xfer
  import dac_ld_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  xfer_req_t        req_i,
  input  logic [CNT_W-1:0] cycles_i,
  output logic             busy_o,
  output logic             done_o,
  output xfer_req_t        done_req_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  xfer_req_t        req_q;

  assign done_o     = busy_q && (cnt_q == CNT_W'(1));
  assign busy_o     = busy_q;
  assign done_req_o = req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      req_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= (cycles_i == '0) ? CNT_W'(1) : cycles_i;
      req_q  <= req_i;
    end else if (done_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/dac_ld_bank.sv
module dac_ld_bank
  import dac_ld_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  xfer_req_t                req_i,
  input  logic                     upd_i,
  output logic [NUM_CH*DATA_W-1:0] latch_o,
  output logic [NUM_CH*DATA_W-1:0] dac_o
);
  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic [DATA_W-1:0] lat_q, out_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               lat_q <= '0;
      else if (load_i && req_i.ch == CH_W'(k))   lat_q <= req_i.word;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     out_q <= '0;
      else if (upd_i)  out_q <= lat_q;
    end

    assign latch_o[k*DATA_W +: DATA_W] = lat_q;
    assign dac_o[k*DATA_W +: DATA_W]   = out_q;
  end
endmodule

// File: rtl/dac_dbuf_loader.sv
module dac_dbuf_loader
  import dac_ld_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic                            rd_en_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [7:0]                      wdata_i,
  input  logic [CNT_W-1:0]                xfer_cycles_i,
  output logic [7:0]                      rdata_o,
  output logic [4*12-1:0]                 latch_o,
  output logic [4*12-1:0]                 dac_o
);
  logic      busy, start, done, upd;
  xfer_req_t req, done_req;

  dac_ld_regif #(.ADDR_W(ADDR_W)) u_regif (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .busy_i(busy), .start_o(start),
    .req_o(req), .upd_o(upd), .rdata_o(rdata_o)
  );

  dac_ld_xfer #(.CNT_W(CNT_W)) u_xfer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .req_i(req),
    .cycles_i(xfer_cycles_i), .busy_o(busy), .done_o(done),
    .done_req_o(done_req)
  );

  dac_ld_bank u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(done), .req_i(done_req),
    .upd_i(upd), .latch_o(latch_o), .dac_o(dac_o)
  );
endmodule

// File: rtl/dac_ld_checker.sv
module dac_ld_checker #(
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              busy_i,
  input logic [47:0]       latch_i,
  input logic [47:0]       dac_i
);
  logic hi_sel;
  assign hi_sel = (addr_i == ADDR_W'(5));

  // R3: idle high-byte write raises busy
  a_r3_busy_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && wr_en_i && hi_sel) |=> busy_i);

  // R4: latches move only during a transfer
  a_r4_latch_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> $stable(latch_i));

  // R7: update read copies every latch
  a_r7_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && hi_sel && !busy_i) |=> (dac_i == $past(latch_i)));

  // R8: update read during busy is dropped
  a_r8_read_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && hi_sel && busy_i) |=> $stable(dac_i));

  // R4: outputs hold without an update read
  a_r4_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && hi_sel) |=> $stable(dac_i));
endmodule

bind dac_dbuf_loader dac_ld_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .addr_i(addr_i), .busy_i(busy), .latch_i(latch_o), .dac_i(dac_o)
);

// File: tb/dac_dbuf_loader_tb.sv
`timescale 1ns/1ps
module dac_dbuf_loader_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        wr = 0, rd = 0;
  logic [3:0]  addr = 0;
  logic [7:0]  wdata = 0;
  logic [7:0]  xcyc = 0;
  logic [7:0]  rdata;
  logic [47:0] latch, dac;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  dac_dbuf_loader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr),
    .wdata_i(wdata), .xfer_cycles_i(xcyc), .rdata_o(rdata),
    .latch_o(latch), .dac_o(dac)
  );

  // behavioural reference
  int lo_m, busy_m, cnt_m, word_m, ch_m;
  int lat_m[4], out_m[4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_m = 0; busy_m = 0; cnt_m = 0; word_m = 0; ch_m = 0;
      for (int k = 0; k < 4; k++) begin lat_m[k] = 0; out_m[k] = 0; end
    end else begin
      int was_busy;
      was_busy = busy_m;
      if (rd && addr == 5 && !was_busy)
        for (int k = 0; k < 4; k++) out_m[k] = lat_m[k];
      if (wr && addr == 5 && !was_busy) begin
        busy_m = 1;
        cnt_m  = (xcyc == 0) ? 1 : int'(xcyc);
        word_m = ((int'(wdata) & 15) << 8) | lo_m;
        ch_m   = int'(wdata) >> 6;
      end else if (was_busy) begin
        if (cnt_m == 1) begin busy_m = 0; lat_m[ch_m] = word_m; end
        else cnt_m--;
      end
      if (wr && addr == 4) lo_m = int'(wdata);
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    for (int k = 0; k < 4; k++) begin
      chk(int'(latch[k*12 +: 12]), lat_m[k], "R4 latch vs model");
      chk(int'(dac[k*12 +: 12]), out_m[k], "R7 output vs model");
    end
    chk(int'(rdata), (rd && addr == 4) ? (busy_m << 7) : 0, "R3 rdata vs model");
  end

  task automatic op(input logic w, input logic r, input int a, input int d);
    @(posedge clk); #1;
    wr = w; rd = r; addr = 4'(a); wdata = 8'(d);
  endtask

  task automatic settle(); #0.5; endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    #12 rst_n = 1;
    // R1 reset state
    op(0, 1, 4, 0); settle();
    chk(int'(latch), 0, "R1 latch reset");
    chk(int'(dac), 0, "R1 output reset");
    chk(int'(rdata), 0, "R1 busy clear");
    // R2/R3/R5/R8 transfer to ch2, bits 5:4 set
    xcyc = 3;
    op(1, 0, 4, 'hAB);
    op(1, 0, 5, 'hB3);
    op(0, 1, 4, 0); settle();
    chk(int'(rdata), 'h80, "R3 busy after hi write");
    xcyc = 1;
    op(1, 0, 5, 'h4F);      // R5 ignored
    op(0, 1, 5, 0);         // R8 read while busy
    op(0, 0, 0, 0); settle();
    chk(int'(dac), 0, "R8 output unchanged");
    op(0, 1, 4, 0); settle();
    chk(int'(latch[24 +: 12]), 'h3AB, "R2 latch ch2 word");
    chk(int'(latch[0 +: 24]), 0, "R5 other latches untouched");
    chk(int'(dac), 0, "R4 output unchanged on load");
    chk(int'(rdata), 0, "R3 busy cleared after N");
    // R7 update
    op(0, 1, 5, 0);
    op(0, 0, 0, 0); settle();
    chk(int'(dac[24 +: 12]), 'h3AB, "R7 update ch2");
    // R6 reuse low byte, xfer 0 acts as 1
    xcyc = 0;
    op(1, 0, 5, 'h01);
    op(0, 1, 4, 0); settle();
    chk(int'(rdata), 'h80, "R3 busy one cycle");
    op(0, 1, 4, 0); settle();
    chk(int'(rdata), 0, "R3 zero length is one");
    chk(int'(latch[0 +: 12]), 'h1AB, "R6 low byte kept");
    // full scale on ch3, then all outputs together
    xcyc = 2;
    op(1, 0, 4, 'hFF);
    op(1, 0, 5, 'hCF);
    op(0, 0, 0, 0); op(0, 0, 0, 0);
    op(0, 1, 5, 0);
    op(0, 0, 0, 0); settle();
    chk(int'(dac[36 +: 12]), 'hFFF, "R7 ch3 full scale");
    chk(int'(dac[0 +: 12]), 'h1AB, "R7 ch0 same edge");
    chk(int'(dac[24 +: 12]), 'h3AB, "R7 ch2 held");
    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int kind, a;
      kind = $urandom % 3;
      a = ($urandom % 4 == 0) ? int'($urandom % 8) : 4 + int'($urandom % 2);
      xcyc = 8'($urandom % 6);
      op(kind == 1, kind == 2, a, int'($urandom % 256));
    end
    op(0, 0, 0, 0);
    @(posedge clk); #1;
    finish_run();
  end
endmodule